// File: doc/BRIEF.md
# Half-Bridge Dead-Time Interlock

This block sits between a PWM source and the two gate drivers of a half-bridge. It takes two switch commands, one for each side of the bridge, and produces two registered drive outputs. It guarantees a minimum interval during which both switches are off whenever control passes from one side to the other.

The minimum interval is set by a dead-time count on a configuration input and is measured in clock cycles. A side is turned off when its own command falls. It is also turned off when both commands are high at once. Either kind of turn-off starts the off-interval for the opposite side, and that side may not switch on until the interval has run out. If the commands already leave a low-low gap longer than the programmed count, the rising side follows its command with only the one-cycle register latency. Both sides behave the same way with their roles swapped.

The commands are expected to be synchronous to the clock already. There is no filtering and no supply supervision in the block.

Top module: `dead_time_interlock`

## Requirements
- R1: `drv_a_o` and `drv_b_o` are never high in the same cycle, whatever the command sequence.
- R2: A drive output is high in a cycle only if, at the previous clock edge, its own command was sampled high and the opposite command was sampled low. Outputs are registered, so latency is one cycle.
- R3: When a command is sampled low, its drive output is low after that same clock edge.
- R4: A turn-off event for a side happens at the edge where the opposite command is first sampled low after being high. With a programmed count D, the output of that side cannot rise before the edge D+1 edges later. With D = 0, it may rise at the very next edge.
- R5: If the opposite side's turn-off event lies at least D+1 edges in the past, a rising command sets its output high at the next edge, with no added delay.
- R6: When both commands are sampled high, both outputs are low after that edge. An output that is forced low this way counts as a turn-off event for the other side, as in R4.
- R7: If a command falls while its own off-interval is still running, its output stays low, and the off-interval of the opposite side restarts from the full count.
- R8: While `rst_ni` is low, both outputs are low. After reset both off-intervals count as already expired, so the first rising command appears at the output one edge later.
- R9: The dead-time count is captured at the turn-off event. A change to `dead_cnt_i` after that edge does not alter the interval already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dead_cnt_i | input | DT_W (10) | Minimum off-interval in clock cycles |
| cmd_a_i | input | 1 | Switch command, side A (synchronous) |
| cmd_b_i | input | 1 | Switch command, side B (synchronous) |
| drv_a_o | output | 1 | Registered drive output, side A |
| drv_b_o | output | 1 | Registered drive output, side B |

## Verification
The assertions assume that the commands and the dead-time count are stable around each rising clock edge, and that they come from the same clock domain. They make no assumption about which command patterns occur. The bench changes every input only on the falling clock edge, so this assumption always holds. The sweeps pass every four-step sequence of command pairs through each of several small dead-time counts, using varied hold lengths. This covers overlap, back-to-back handovers, and gaps both shorter and longer than the count. Only the R9 test changes `dead_cnt_i` while an interval is running.

// File: rtl/dti_pkg.sv
package dti_pkg;
  localparam int unsigned NUM_CH = 2;
  typedef enum logic {CH_A = 1'b0, CH_B = 1'b1} ch_e;
endpackage

// File: rtl/dti_timer.sv
module dti_timer #(
  parameter int unsigned DT_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [DT_W-1:0] dead_cnt_i,
  output logic            expired_o
);
  logic [DT_W-1:0] cnt_q;

  // reset leaves the interval expired
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= dead_cnt_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - DT_W'(1);
  end

  assign expired_o = (cnt_q == '0);

  a_r9_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(dead_cnt_i));
  a_r4_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - DT_W'(1));
endmodule

// File: rtl/dti_chan.sv
module dti_chan #(
  parameter int unsigned DT_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DT_W-1:0] dead_cnt_i,
  input  logic            cmd_own_i,
  input  logic            cmd_opp_i,
  input  logic            cmd_opp_q_i,
  input  logic            drv_opp_i,
  output logic            drv_o
);
  logic evt, expired, drv_d, drv_q;

  // opposite side turns off: its command fell, or overlap forces it low
  assign evt = (cmd_opp_q_i & ~cmd_opp_i) | (drv_opp_i & cmd_own_i & cmd_opp_i);

  dti_timer #(.DT_W(DT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (evt),
    .dead_cnt_i (dead_cnt_i),
    .expired_o  (expired)
  );

  assign drv_d = cmd_own_i & ~cmd_opp_i & expired & ~evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drv_q <= 1'b0;
    else         drv_q <= drv_d;
  end

  assign drv_o = drv_q;

  a_r4_no_early_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_q) |-> $past(expired));
  a_r7_opp_fall_holds_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_opp_q_i && !cmd_opp_i) |=> !drv_q);
endmodule

// File: rtl/dead_time_interlock.sv
module dead_time_interlock
  import dti_pkg::*;
#(
  parameter int unsigned DT_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DT_W-1:0] dead_cnt_i,
  input  logic            cmd_a_i,
  input  logic            cmd_b_i,
  output logic            drv_a_o,
  output logic            drv_b_o
);
  logic [NUM_CH-1:0] cmd, cmd_q, drv;

  assign cmd[CH_A] = cmd_a_i;
  assign cmd[CH_B] = cmd_b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= '0;
    else         cmd_q <= cmd;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned OPP = NUM_CH - 1 - c;
    dti_chan #(.DT_W(DT_W)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .dead_cnt_i  (dead_cnt_i),
      .cmd_own_i   (cmd[c]),
      .cmd_opp_i   (cmd[OPP]),
      .cmd_opp_q_i (cmd_q[OPP]),
      .drv_opp_i   (drv[OPP]),
      .drv_o       (drv[c])
    );

    a_r3_fall_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cmd[c] |=> !drv[c]);
    a_r2_needs_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drv[c] |-> $past(cmd[c] && !cmd[OPP]));
  end

  assign drv_a_o = drv[CH_A];
  assign drv_b_o = drv[CH_B];

  a_r1_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drv_a_o && drv_b_o));
  a_r6_overlap_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_a_i && cmd_b_i) |=> (!drv_a_o && !drv_b_o));
  a_r8_reset_low: assert property (@(posedge clk_i)
    !rst_ni |-> (!drv_a_o && !drv_b_o));
endmodule

// File: tb/test_dead_time_interlock.sv
module test_dead_time_interlock;
  localparam int unsigned DT_W = 10;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DT_W-1:0] dt = '0;
  logic in_a = 1'b0, in_b = 1'b0;
  logic drv_a, drv_b;

  int n_vec = 0, n_miss = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  dead_time_interlock #(.DT_W(DT_W)) i_dead_time_interlock (
    .clk_i(clk), .rst_ni(rst_n), .dead_cnt_i(dt),
    .cmd_a_i(in_a), .cmd_b_i(in_b), .drv_a_o(drv_a), .drv_b_o(drv_b)
  );

  // timestamp model: rise allowed when edge - event_edge > captured count
  longint cyc;
  longint evt_at [2];
  longint evt_dt [2];
  bit pin_q [2];
  bit pout [2];

  always @(posedge clk) begin
    bit in [2];
    bit ev [2];
    bit nout [2];
    in[0] = in_a; in[1] = in_b;
    if (!rst_n) begin
      cyc = 0;
      for (int x = 0; x < 2; x++) begin
        evt_at[x] = -100000; evt_dt[x] = 0; pin_q[x] = 0; pout[x] = 0;
      end
    end else begin
      for (int x = 0; x < 2; x++) begin
        ev[x] = (pin_q[1-x] && !in[1-x]) || (pout[1-x] && in[x] && in[1-x]);
        nout[x] = in[x] && !in[1-x] && !ev[x] && (cyc - evt_at[x] > evt_dt[x]);
      end
      for (int x = 0; x < 2; x++) begin
        if (ev[x]) begin evt_at[x] = cyc; evt_dt[x] = longint'(dt); end
        pout[x] = nout[x];
        pin_q[x] = in[x];
      end
      cyc++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_miss++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison
  always @(negedge clk) begin
    if (rst_n && chk_en && !done) begin
      check(!(drv_a && drv_b), "R1 exclusive", {drv_a, drv_b}, 0);
      if (drv_a !== pout[0] || drv_b !== pout[1]) begin
        if (pin_q[0] && pin_q[1])
          check(1'b0, "R6 overlap", {drv_a, drv_b}, {pout[0], pout[1]});
        else if (!pout[0] && !pout[1] && (pin_q[0] ^ pin_q[1]))
          check(1'b0, "R4 dead time", {drv_a, drv_b}, {pout[0], pout[1]});
        else
          check(1'b0, "R2 follow", {drv_a, drv_b}, {pout[0], pout[1]});
      end else n_vec++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input bit a, input bit b);
    in_a = a; in_b = b;
  endtask

  task automatic do_reset(input int d);
    @(negedge clk);
    rst_n = 1'b0; drive(0, 0); dt = DT_W'(d);
    tick(2);
    check(!drv_a && !drv_b, "R8 reset low", {drv_a, drv_b}, 0);
    rst_n = 1'b1;
  endtask

  // counts edges from the drive point until the chosen output is high
  task automatic edges_to_rise(input bit which_b, output int n);
    n = 0;
    do begin
      tick(1); n++;
    end while (!(which_b ? drv_b : drv_a) && n < 2000);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_miss++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    int n;
    chk_en = 1'b1;

    // near-exhaustive sweep: all 4-step command sequences, small counts
    for (int d = 0; d < 5; d++) begin
      do_reset(d);
      for (int seq = 0; seq < 256; seq++) begin
        for (int st = 0; st < 4; st++) begin
          drive(seq[2*st+1], seq[2*st]);
          tick(1 + ((seq * 7 + st * 5 + d) % 6));
        end
      end
    end

    // R8: timers expired after reset
    do_reset(7);
    drive(1, 0); tick(1);
    check(drv_a == 1'b1, "R8 first rise", drv_a, 1);

    // R4: handover with count 20, rise at edge D+1 after the event edge
    do_reset(20);
    drive(1, 0); tick(3);
    drive(0, 1); edges_to_rise(1'b1, n);
    check(n == 22, "R4 handover gap", n, 22);

    // R4: count 0, rise on the edge after the event edge
    do_reset(0);
    drive(0, 1); tick(3);
    drive(1, 0); edges_to_rise(1'b0, n);
    check(n == 2, "R4 zero count", n, 2);

    // R3: falling command clears its output after one edge
    do_reset(2);
    drive(0, 1); tick(3);
    drive(0, 0); tick(1);
    check(drv_b == 1'b0, "R3 fall low", drv_b, 0);

    // R5: long input gap passes straight through
    do_reset(5);
    drive(1, 0); tick(3);
    drive(0, 0); tick(10);
    drive(0, 1); tick(1);
    check(drv_b == 1'b1, "R5 pass through", drv_b, 1);

    // R6: overlap forces both low, then the forced-off side is reloaded
    do_reset(3);
    drive(1, 0); tick(3);
    drive(1, 1); tick(1);
    check(!drv_a && !drv_b, "R6 overlap low", {drv_a, drv_b}, 0);
    drive(1, 0); edges_to_rise(1'b0, n);
    check(n == 5, "R6 reload after overlap", n, 5);

    // R7: A falls while its own interval runs, B's interval restarts
    do_reset(6);
    drive(0, 1); tick(4);
    drive(0, 0); tick(1);
    drive(1, 0); tick(1);
    check(drv_a == 1'b0, "R7 held low", drv_a, 0);
    drive(0, 0); tick(1);
    check(drv_a == 1'b0, "R7 stays low", drv_a, 0);
    drive(0, 1); edges_to_rise(1'b1, n);
    check(n == 7, "R7 restart full count", n, 7);

    // R9: count captured at the event edge
    do_reset(8);
    drive(1, 0); tick(3);
    drive(0, 1); tick(1); dt = '0;
    edges_to_rise(1'b1, n);
    check(n + 1 == 10, "R9 captured count", n + 1, 10);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end
endmodule